// File: doc/BRIEF.md
# Instruction Prefix Scanner

This block looks at the front of one variable-length instruction and works out its prefix bytes. The caller loads a window of instruction bytes and says how many of them are valid. It also says whether the core runs in 64-bit mode. After a single start pulse the block walks the window one byte per cycle.

As it walks, it keeps up to four distinct legacy prefixes and counts every legacy byte it passes, repeats included. It applies the operand-size and address-size toggles, then looks for an optional REX byte and an optional 2- or 3-byte vector prefix. When it finishes it raises a one-cycle `done` pulse and presents:
- the four prefix slots;
- the number of legacy prefix bytes;
- the REX byte;
- the vector-prefix bytes and their length;
- the effective operand and address sizes, in bytes;
- the offset of the first opcode byte in the window.

If a byte the scan needs lies beyond the valid count, `err` is set with the pulse, and every other result is then invalid.

Control is a five-state machine:
- IDLE waits for `start`, latches the window and mode, and moves to SCAN.
- SCAN stays while the current byte is a legacy prefix.
- SCAN moves to FIX on the first non-prefix byte, or on a fifth distinct prefix.
- SCAN returns to IDLE with an error if the window is exhausted.
- FIX puts the last prefix into slot 3, then moves to REX in 64-bit mode and to VEX otherwise.
- REX consumes a REX byte if one is present, then moves to VEX.
- VEX consumes a vector prefix if one is accepted, then returns to IDLE, raising `done` either way.

Top module: `pscan_top`

## Requirements
- R1: On each start the operand size begins at 4 bytes. The address size begins at 8 bytes when `mode64` is 1 and at 4 bytes when it is 0.
- R2: Legacy prefixes are F0, F2, F3, 2E, 36, 3E, 26, 64, 65, 66 and 67 (hex). A byte equal to one already stored is consumed and counted in `pfx_count`, but is not stored again and does not toggle any size. Slot i occupies `pfx_slots[8i+7:8i]`.
- R3: When a fifth distinct legacy prefix appears while all four slots are full, scanning stops. That byte is not consumed and `pfx_ovf` is 1.
- R4: Each stored 67 toggles the address size, between 8 and 4 in 64-bit mode and between 4 and 2 otherwise.
- R5: Each stored 66 toggles the operand size between 4 and 2.
- R6: After scanning, slot 3 holds the last legacy byte consumed. If slot 3 held a different nonzero prefix, that prefix replaces the last byte wherever the last byte is stored in the slots.
- R7: In 64-bit mode only, a byte 40..4F after the legacy prefixes is consumed as REX and reported on `rex_byte`/`rex_hit`. If its bit 3 is set, the operand size becomes 8.
- R8: In 32-bit mode, a C4 or C5 byte is taken as a vector prefix only if the byte after it has bits 7:6 equal to 11. Otherwise nothing is consumed and `vex_len` is 0.
- R9: C5 consumes 2 bytes and C4 consumes 3 bytes. `vex_len` gives that count, and `vex_bytes` holds the bytes in order, lowest byte first. In 64-bit mode, C4 whose third byte has bit 7 set makes the operand size 8.
- R10: If any byte the scan must read, including both look-ahead bytes of a vector lead, lies at or beyond `win_len` (capped at the window size), `err` is 1 with `done`.
- R11: `opc_offset` is the count of all bytes consumed: legacy, REX and vector prefix.
- R12: After reset `done`, `busy` and `err` are 0. `done` is a pulse one cycle long, and `start` is taken only while `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a scan of the presented window |
| mode64 | input | 1 | 1 selects 64-bit mode |
| win_bytes | input | WIN*8 | Instruction bytes, byte 0 in bits 7:0 |
| win_len | input | IW | Number of valid bytes in the window |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle result pulse |
| err | output | 1 | Window ran out; results invalid |
| pfx_ovf | output | 1 | Scan stopped on a fifth distinct prefix |
| pfx_slots | output | SLOTS*8 | Stored legacy prefixes, slot 0 lowest |
| pfx_count | output | IW | Legacy prefix bytes consumed |
| rex_hit | output | 1 | REX byte consumed |
| rex_byte | output | 8 | REX byte value |
| vex_len | output | 2 | Vector prefix length: 0, 2 or 3 |
| vex_bytes | output | 24 | Vector prefix bytes, first byte lowest |
| opnd_size | output | 4 | Effective operand size in bytes |
| addr_size | output | 4 | Effective address size in bytes |
| opc_offset | output | IW | Offset of first opcode byte |

## Verification
The case that matters most is a single byte that matches a stored prefix while all four slots are already full. In that cycle the duplicate test and the overflow stop both see the same byte. The duplicate test must win: the byte is counted and consumed, and the overflow flag stays low. The bench provokes this with four distinct prefixes followed by a repeat of the second one. The scoreboard judges it by `pfx_count`, `pfx_ovf` and `opc_offset`, and sets it against a run where the fifth byte is new, so stopping is the correct result.

// File: rtl/pscan_pkg.sv
package pscan_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_FIX,
        ST_REX,
        ST_VEX
    } pscan_state_e;

    localparam logic [7:0] PB_OPSZ = 8'h66;
    localparam logic [7:0] PB_ADSZ = 8'h67;
    localparam logic [7:0] PB_VEX2 = 8'hC5;
    localparam logic [7:0] PB_VEX3 = 8'hC4;

    localparam logic [3:0] SZ2 = 4'd2;
    localparam logic [3:0] SZ4 = 4'd4;
    localparam logic [3:0] SZ8 = 4'd8;

    localparam logic [3:0] ADSZ_FLIP64 = 4'd12;
    localparam logic [3:0] ADSZ_FLIP32 = 4'd6;
    localparam logic [3:0] OPSZ_FLIP   = 4'd6;

endpackage

// File: rtl/pscan_classify.sv
module pscan_classify
    import pscan_pkg::*;
(
    input  logic [7:0] byte_in,
    output logic       is_legacy,
    output logic       is_opsz,
    output logic       is_adsz,
    output logic       is_rex,
    output logic       is_vex2,
    output logic       is_vex3
);

    always_comb begin
        case (byte_in)
            8'hF0, 8'hF2, 8'hF3,
            8'h2E, 8'h36, 8'h3E, 8'h26,
            8'h64, 8'h65,
            8'h66, 8'h67: is_legacy = 1'b1;
            default:      is_legacy = 1'b0;
        endcase
        is_opsz = (byte_in == PB_OPSZ);
        is_adsz = (byte_in == PB_ADSZ);
        is_rex  = (byte_in[7:4] == 4'h4);
        is_vex2 = (byte_in == PB_VEX2);
        is_vex3 = (byte_in == PB_VEX3);
    end

endmodule

// File: rtl/pscan_slot_bank.sv
module pscan_slot_bank
    import pscan_pkg::*;
#(
    parameter  int SLOTS = 4,
    localparam int CW    = $clog2(SLOTS + 1),
    localparam int LAST  = SLOTS - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               push,
    input  logic [7:0]         push_byte,
    input  logic               fix,
    input  logic [7:0]         fix_byte,
    input  logic [7:0]         probe,
    output logic [SLOTS*8-1:0] slots_flat,
    output logic               dup,
    output logic               full
);

    logic [7:0]       slot_q [SLOTS];
    logic [CW-1:0]    used_q;
    logic [SLOTS-1:0] hit;
    logic             do_fix;
    logic             do_swap;

    // last byte goes to the top slot; a displaced top value swaps down
    assign do_fix  = fix && (fix_byte != 8'h00) && (fix_byte != slot_q[LAST]);
    assign do_swap = do_fix && (slot_q[LAST] != 8'h00);
    assign dup     = |hit;
    assign full    = (used_q == CW'(SLOTS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    used_q <= '0;
        else if (clr)  used_q <= '0;
        else if (push) used_q <= used_q + 1'b1;
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        assign hit[g] = (CW'(g) < used_q) && (slot_q[g] == probe);
        assign slots_flat[g*8 +: 8] = slot_q[g];

        if (g == LAST) begin : g_top
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                              slot_q[g] <= '0;
                else if (clr)                            slot_q[g] <= '0;
                else if (push && used_q == CW'(g))       slot_q[g] <= push_byte;
                else if (do_fix)                         slot_q[g] <= fix_byte;
            end
        end else begin : g_low
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                              slot_q[g] <= '0;
                else if (clr)                            slot_q[g] <= '0;
                else if (push && used_q == CW'(g))       slot_q[g] <= push_byte;
                else if (do_swap && CW'(g) < used_q && slot_q[g] == fix_byte)
                                                         slot_q[g] <= slot_q[LAST];
            end
        end
    end

    assert_used_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        used_q <= CW'(SLOTS));

    assert_push_room_R3: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    assert_last_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fix && fix_byte != 8'h00 && !clr) |=> slot_q[LAST] == $past(fix_byte));

endmodule

// File: rtl/pscan_top.sv
module pscan_top
    import pscan_pkg::*;
#(
    parameter  int WIN   = 16,
    parameter  int SLOTS = 4,
    localparam int IW    = $clog2(WIN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               mode64,
    input  logic [WIN*8-1:0]   win_bytes,
    input  logic [IW-1:0]      win_len,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic               pfx_ovf,
    output logic [SLOTS*8-1:0] pfx_slots,
    output logic [IW-1:0]      pfx_count,
    output logic               rex_hit,
    output logic [7:0]         rex_byte,
    output logic [1:0]         vex_len,
    output logic [23:0]        vex_bytes,
    output logic [3:0]         opnd_size,
    output logic [3:0]         addr_size,
    output logic [IW-1:0]      opc_offset
);

    localparam int AW = IW + 1;

    pscan_state_e state_q, state_d;

    logic [7:0]    wq [WIN];
    logic [AW-1:0] cnt_q;
    logic [AW-1:0] idx_q;
    logic [IW-1:0] pcnt_q;
    logic          mode_q;
    logic [7:0]    lb_q;
    logic [3:0]    opnd_q, addr_q;
    logic          rexh_q;
    logic [7:0]    rexb_q;
    logic [1:0]    vlen_q;
    logic [23:0]   vexb_q;
    logic          ovf_q, done_q, err_q;

    logic [7:0] b0, b1, b2;
    logic       have0, have1, have2;
    logic       c_legacy, c_opsz, c_adsz, c_rex, c_vex2, c_vex3;
    logic       bank_dup, bank_full;
    logic       finish, fail, push, count, fix, ovf_set, vex_take, take_start;

    function automatic logic [7:0] pick(input logic [AW-1:0] pos);
        logic [7:0] r;
        r = 8'h00;
        for (int i = 0; i < WIN; i++)
            if (pos == AW'(i)) r = wq[i];
        return r;
    endfunction

    assign b0    = pick(idx_q);
    assign b1    = pick(idx_q + AW'(1));
    assign b2    = pick(idx_q + AW'(2));
    assign have0 = idx_q < cnt_q;
    assign have1 = (idx_q + AW'(1)) < cnt_q;
    assign have2 = (idx_q + AW'(2)) < cnt_q;

    assign take_start = (state_q == ST_IDLE) && start;

    pscan_classify u_cls (
        .byte_in  (b0),
        .is_legacy(c_legacy),
        .is_opsz  (c_opsz),
        .is_adsz  (c_adsz),
        .is_rex   (c_rex),
        .is_vex2  (c_vex2),
        .is_vex3  (c_vex3)
    );

    pscan_slot_bank #(.SLOTS(SLOTS)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (take_start),
        .push      (push),
        .push_byte (b0),
        .fix       (fix),
        .fix_byte  (lb_q),
        .probe     (b0),
        .slots_flat(pfx_slots),
        .dup       (bank_dup),
        .full      (bank_full)
    );

    // vector prefix acceptance: lead byte, look-ahead present, 32-bit form check
    assign vex_take = (state_q == ST_VEX) && have0 && (c_vex2 || c_vex3) && have1 &&
                      (mode_q || b1[7:6] == 2'b11) && (!c_vex3 || have2);

    always_comb begin
        state_d = state_q;
        finish  = 1'b0;
        fail    = 1'b0;
        push    = 1'b0;
        count   = 1'b0;
        fix     = 1'b0;
        ovf_set = 1'b0;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_SCAN;
            ST_SCAN: begin
                if (!have0) begin
                    fail    = 1'b1;
                    state_d = ST_IDLE;
                end else if (c_legacy) begin
                    if (bank_dup) begin
                        count = 1'b1;
                    end else if (bank_full) begin
                        ovf_set = 1'b1;
                        state_d = ST_FIX;
                    end else begin
                        push  = 1'b1;
                        count = 1'b1;
                    end
                end else begin
                    state_d = ST_FIX;
                end
            end
            ST_FIX: begin
                fix     = 1'b1;
                state_d = mode_q ? ST_REX : ST_VEX;
            end
            ST_REX: begin
                if (!have0) begin
                    fail    = 1'b1;
                    state_d = ST_IDLE;
                end else begin
                    state_d = ST_VEX;
                end
            end
            ST_VEX: begin
                state_d = ST_IDLE;
                if (!have0)                                  fail   = 1'b1;
                else if (!(c_vex2 || c_vex3))                finish = 1'b1;
                else if (!have1)                             fail   = 1'b1;
                else if (!mode_q && b1[7:6] != 2'b11)        finish = 1'b1;
                else if (c_vex3 && !have2)                   fail   = 1'b1;
                else                                         finish = 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WIN; i++) wq[i] <= '0;
            cnt_q  <= '0;
            idx_q  <= '0;
            pcnt_q <= '0;
            mode_q <= 1'b0;
            lb_q   <= '0;
            opnd_q <= SZ4;
            addr_q <= SZ4;
            rexh_q <= 1'b0;
            rexb_q <= '0;
            vlen_q <= '0;
            vexb_q <= '0;
            ovf_q  <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= finish | fail;
            if (finish | fail) err_q <= fail;
            unique case (state_q)
                ST_IDLE: if (start) begin
                    for (int i = 0; i < WIN; i++) wq[i] <= win_bytes[i*8 +: 8];
                    cnt_q  <= (AW'(win_len) > AW'(WIN)) ? AW'(WIN) : AW'(win_len);
                    mode_q <= mode64;
                    idx_q  <= '0;
                    pcnt_q <= '0;
                    lb_q   <= '0;
                    opnd_q <= SZ4;
                    addr_q <= mode64 ? SZ8 : SZ4;
                    rexh_q <= 1'b0;
                    rexb_q <= '0;
                    vlen_q <= '0;
                    vexb_q <= '0;
                    ovf_q  <= 1'b0;
                    err_q  <= 1'b0;
                end
                ST_SCAN: begin
                    if (count) begin
                        pcnt_q <= pcnt_q + 1'b1;
                        idx_q  <= idx_q + AW'(1);
                        lb_q   <= b0;
                    end
                    if (push && c_opsz) opnd_q <= opnd_q ^ OPSZ_FLIP;
                    if (push && c_adsz) addr_q <= addr_q ^ (mode_q ? ADSZ_FLIP64 : ADSZ_FLIP32);
                    if (ovf_set) ovf_q <= 1'b1;
                end
                ST_FIX: ;
                ST_REX: if (have0 && c_rex) begin
                    rexh_q <= 1'b1;
                    rexb_q <= b0;
                    idx_q  <= idx_q + AW'(1);
                    if (b0[3]) opnd_q <= SZ8;
                end
                ST_VEX: if (vex_take) begin
                    vexb_q <= {c_vex3 ? b2 : 8'h00, b1, b0};
                    vlen_q <= c_vex3 ? 2'd3 : 2'd2;
                    idx_q  <= idx_q + (c_vex3 ? AW'(3) : AW'(2));
                    if (c_vex3 && mode_q && b2[7]) opnd_q <= SZ8;
                end
                default: ;
            endcase
        end
    end

    assign busy       = (state_q != ST_IDLE);
    assign done       = done_q;
    assign err        = err_q;
    assign pfx_ovf    = ovf_q;
    assign pfx_count  = pcnt_q;
    assign rex_hit    = rexh_q;
    assign rex_byte   = rexb_q;
    assign vex_len    = vlen_q;
    assign vex_bytes  = vexb_q;
    assign opnd_size  = opnd_q;
    assign addr_size  = addr_q;
    assign opc_offset = idx_q[IW-1:0];

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_size_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> ((addr_q == SZ2 || addr_q == SZ4 || addr_q == SZ8) &&
                            (opnd_q == SZ2 || opnd_q == SZ4 || opnd_q == SZ8)));

    assert_rex_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rex_hit) |-> mode_q);

    assert_vex_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> vex_len != 2'd1);

    assert_vex32_form_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err && !mode_q && vex_len != 2'd0) |-> vex_bytes[15:14] == 2'b11);

    assert_offset_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> idx_q <= cnt_q);

    assert_ovf_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && pfx_ovf) |-> bank_full);

endmodule

// File: tb/pscan_top_test.sv
`timescale 1ns/1ps
module pscan_top_test;

    localparam int WIN   = 16;
    localparam int SLOTS = 4;
    localparam int IW    = $clog2(WIN + 1);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic               mode64 = 1'b0;
    logic [WIN*8-1:0]   win_bytes = '0;
    logic [IW-1:0]      win_len = '0;
    logic               busy, done, err, pfx_ovf, rex_hit;
    logic [SLOTS*8-1:0] pfx_slots;
    logic [IW-1:0]      pfx_count, opc_offset;
    logic [7:0]         rex_byte;
    logic [1:0]         vex_len;
    logic [23:0]        vex_bytes;
    logic [3:0]         opnd_size, addr_size;

    pscan_top #(.WIN(WIN), .SLOTS(SLOTS)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode64(mode64),
        .win_bytes(win_bytes), .win_len(win_len), .busy(busy), .done(done),
        .err(err), .pfx_ovf(pfx_ovf), .pfx_slots(pfx_slots), .pfx_count(pfx_count),
        .rex_hit(rex_hit), .rex_byte(rex_byte), .vex_len(vex_len),
        .vex_bytes(vex_bytes), .opnd_size(opnd_size), .addr_size(addr_size),
        .opc_offset(opc_offset)
    );

    always #10 clk = ~clk;

    typedef struct {
        string       tag;
        bit          err;
        bit          ovf;
        logic [31:0] slots;
        int          cnt;
        bit          rh;
        logic [7:0]  rb;
        int          vl;
        logic [23:0] vb;
        int          op;
        int          ad;
        int          off;
    } exp_t;

    exp_t q[$];
    int   total = 0;
    int   bad   = 0;
    bit   ended = 0;
    bit   pend  = 0;

    function automatic bit is_leg(logic [7:0] b);
        case (b)
            8'hF0, 8'hF2, 8'hF3, 8'h2E, 8'h36, 8'h3E, 8'h26,
            8'h64, 8'h65, 8'h66, 8'h67: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // expected result from the requirement text
    function automatic exp_t model(string tag, bit m64, int n, logic [7:0] w[8]);
        exp_t e;
        logic [7:0] s[4];
        int idx = 0, nb = 0;
        logic [7:0] lb = 0;
        bit seen;
        e = '{tag, 0, 0, 0, 0, 0, 0, 0, 0, 4, (m64 ? 8 : 4), 0};
        for (int i = 0; i < 4; i++) s[i] = 0;
        forever begin
            if (idx >= n) begin e.err = 1; return e; end
            if (!is_leg(w[idx])) break;
            seen = 0;
            for (int i = 0; i < nb; i++) if (s[i] == w[idx]) seen = 1;
            if (!seen) begin
                if (nb == 4) begin e.ovf = 1; break; end
                s[nb] = w[idx];
                nb++;
                if (w[idx] == 8'h66) e.op = (e.op == 4) ? 2 : 4;
                if (w[idx] == 8'h67) e.ad = m64 ? ((e.ad == 8) ? 4 : 8) : ((e.ad == 4) ? 2 : 4);
            end
            e.cnt++;
            lb = w[idx];
            idx++;
        end
        if (lb != 0 && lb != s[3]) begin
            if (s[3] != 0)
                for (int i = 0; i < nb; i++) if (s[i] == lb) s[i] = s[3];
            s[3] = lb;
        end
        e.slots = {s[3], s[2], s[1], s[0]};
        if (m64) begin
            if (idx >= n) begin e.err = 1; return e; end
            if (w[idx][7:4] == 4'h4) begin
                e.rh = 1; e.rb = w[idx];
                if (w[idx][3]) e.op = 8;
                idx++;
            end
        end
        if (idx >= n) begin e.err = 1; return e; end
        if (w[idx] == 8'hC4 || w[idx] == 8'hC5) begin
            if (idx + 1 >= n) begin e.err = 1; return e; end
            if (m64 || w[idx+1][7:6] == 2'b11) begin
                if (w[idx] == 8'hC4) begin
                    if (idx + 2 >= n) begin e.err = 1; return e; end
                    e.vl = 3; e.vb = {w[idx+2], w[idx+1], w[idx]};
                    if (m64 && w[idx+2][7]) e.op = 8;
                    idx += 3;
                end else begin
                    e.vl = 2; e.vb = {8'h00, w[idx+1], w[idx]};
                    idx += 2;
                end
            end
        end
        e.off = idx;
        return e;
    endfunction

    task automatic chk(string tag, string fld, longint act, longint expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, fld, act, expv);
        end
    endtask

    // monitor: pops one expected item per done pulse
    always @(negedge clk) begin
        exp_t e;
        if (pend) begin
            chk("R12 pulse width", "done", done, 0);
            pend = 0;
        end
        if (done && rst_n) begin
            pend = 1;
            if (q.size() == 0) begin
                chk("R12 unexpected done", "queue", 0, 1);
            end else begin
                e = q.pop_front();
                chk(e.tag, "err", err, e.err);
                if (!e.err) begin
                    chk(e.tag, "ovf", pfx_ovf, e.ovf);
                    chk(e.tag, "slots", pfx_slots, e.slots);
                    chk(e.tag, "count R2", pfx_count, e.cnt);
                    chk(e.tag, "rex_hit", rex_hit, e.rh);
                    if (e.rh) chk(e.tag, "rex_byte", rex_byte, e.rb);
                    chk(e.tag, "vex_len", vex_len, e.vl);
                    if (e.vl != 0) chk(e.tag, "vex_bytes", vex_bytes, e.vb);
                    chk(e.tag, "opnd", opnd_size, e.op);
                    chk(e.tag, "addr", addr_size, e.ad);
                    chk(e.tag, "offset R11", opc_offset, e.off);
                end
            end
        end
    end

    // driver: pushes the expected item, then issues one scan
    task automatic go(string tag, bit m64, int n,
                      logic [7:0] a0 = 0, logic [7:0] a1 = 0, logic [7:0] a2 = 0,
                      logic [7:0] a3 = 0, logic [7:0] a4 = 0, logic [7:0] a5 = 0,
                      logic [7:0] a6 = 0, logic [7:0] a7 = 0);
        logic [7:0] w[8];
        w = '{a0, a1, a2, a3, a4, a5, a6, a7};
        q.push_back(model(tag, m64, n, w));
        @(negedge clk);
        while (busy) @(negedge clk);
        win_bytes = '0;
        for (int i = 0; i < 8; i++) win_bytes[i*8 +: 8] = w[i];
        win_len = IW'(n);
        mode64  = m64;
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        if (!ended) begin
            ended = 1;
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R12 reset", "done", done, 0);
        chk("R12 reset", "busy", busy, 0);
        chk("R12 reset", "err", err, 0);
        rst_n = 1'b1;
        @(negedge clk);

        go("R1 R11 plain 64-bit", 1, 3, 8'h90);
        go("R1 plain 32-bit", 0, 3, 8'h90);
        go("R2 R5 repeated 66", 1, 5, 8'h66, 8'h66, 8'hF3, 8'h90);
        go("R4 addr 64-bit", 1, 3, 8'h67, 8'h90);
        go("R4 addr 32-bit", 0, 3, 8'h67, 8'h90);
        go("R4 R5 both 32-bit", 0, 4, 8'h66, 8'h67, 8'h90);
        go("R3 fifth distinct", 1, 7, 8'hF0, 8'h2E, 8'h36, 8'h3E, 8'h26, 8'h90);
        go("R2 R3 repeat when full", 1, 7, 8'hF0, 8'h2E, 8'h36, 8'h3E, 8'h2E, 8'h90);
        go("R6 swap into slot3", 1, 7, 8'hF0, 8'h2E, 8'h36, 8'h3E, 8'hF0, 8'h90);
        go("R6 last to slot3", 0, 4, 8'h2E, 8'hF2, 8'h90);
        go("R7 R5 rex W", 1, 4, 8'h66, 8'h48, 8'h90);
        go("R7 rex no W", 1, 3, 8'h41, 8'h90);
        go("R7 rex ignored 32-bit", 0, 3, 8'h41, 8'h90);
        go("R8 lead left as opcode", 0, 4, 8'hC5, 8'h06, 8'h90);
        go("R8 vex2 32-bit", 0, 4, 8'hC5, 8'hF8, 8'h90);
        go("R9 vex3 W 64-bit", 1, 5, 8'hC4, 8'hE2, 8'hF9, 8'h90);
        go("R9 vex3 W 32-bit", 0, 5, 8'hC4, 8'hE2, 8'hF9, 8'h90);
        go("R9 vex2 64-bit", 1, 4, 8'hF3, 8'hC5, 8'hF8, 8'h90);
        go("R10 prefixes exhaust window", 1, 2, 8'h66, 8'h66);
        go("R10 vex3 truncated", 1, 2, 8'hC4, 8'hE2);
        go("R10 empty window", 0, 0);
        go("R1 R10 recovery after error", 1, 3, 8'h90);

        repeat (4) @(negedge clk);
        chk("R12 scoreboard drained", "queue", q.size(), 0);
        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule